// File: doc/BRIEF.md
# Edge-Kicked Watchdog Timer

This block watches a software heartbeat line and drops an active-low alarm when the heartbeat stops. It runs from a fixed timebase clock; every clock cycle is one tick. Any change of level on the kick line, rising or falling, restarts a full countdown of `TIMEOUT_TICKS` ticks. If the countdown runs out before the next change, the alarm output goes low. It stays low until the kick line moves again.

Two conditions hold the timer cleared and stopped. One is a flag saying the kick line is undriven. The other is a system reset flag. While either is set, no timeout can occur, and counting resumes only after a fresh kick. A separate supply-good flag overrides the alarm. When the supply is bad the output is low at once, and it goes high again in the same cycle the supply recovers. The kick line is asynchronous and passes through a synchroniser before edge detection. The undriven, reset and supply flags are taken as synchronous to the timebase.

Top module: `wdk_monitor`

## Requirements
- R1: After the block reset (`rst_ni` low) is released, with the supply good, `wdo_no` is high and the timer is idle.
- R2: A rising edge and a falling edge on `kick_i` both count as activity. Each one restarts a full countdown, so kicks spaced closer than `TIMEOUT_TICKS` keep `wdo_no` high.
- R3: Suppose `kick_i` changes just before clock edge P1. The countdown is then loaded at P3, and `wdo_no` goes low at edge P3+`TIMEOUT_TICKS` if no further change arrives. It stays low until the next change, which raises it at that change's own P3.
- R4: While `kick_hiz_i` is high, the timer is cleared from the next edge and does not count. `wdo_no` is high, given a good supply, however `kick_i` moves.
- R5: While `rst_active_i` is high, the timer is held cleared and `wdo_no` is high, given a good supply. After it falls, no timeout occurs until a `kick_i` change has been seen.
- R6: When `supply_ok_i` is low, `wdo_no` is low in the same cycle. It returns high in the same cycle `supply_ok_i` returns high, unless the timer has expired.
- R7: A `kick_i` level held for a single clock cycle is recognised as activity.
- R8: A kick whose countdown load falls on the same edge as an expiry takes priority. `wdo_no` stays high and a new full countdown starts.
- R9: When `kick_hiz_i` falls, the synchronised level at that moment is taken as the history and does not count as a kick. A level that differs from the one before the undriven period therefore does not arm the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timebase clock, one tick per cycle |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| kick_i | input | 1 | Heartbeat line, asynchronous |
| kick_hiz_i | input | 1 | High when the heartbeat line is undriven |
| supply_ok_i | input | 1 | High when the monitored supply is above threshold |
| rst_active_i | input | 1 | High while the system reset is asserted |
| wdo_no | output | 1 | Active-low watchdog alarm |

## Verification
The bound checker checks three things on every cycle: the supply override, the forced-high output one cycle after an undriven or reset condition, and that an expiry never coincides with a kick edge. It also checks that an alarm is only released by a kick edge or a clear condition. The exact expiry cycle cannot be seen by a property of this form. Neither can the full restart by either edge polarity, the recognition of single-cycle pulses, or the non-counting of the level taken on leaving the undriven state. Only the bench's scenarios, compared against its behavioural model, show these.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

   typedef enum logic [1:0] {
      WD_IDLE = 2'd0,
      WD_RUN  = 2'd1,
      WD_TRIP = 2'd2
   } wd_state_e;

endpackage

// File: rtl/wdk_sync.sv
module wdk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] stage_q;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) stage_q[g] <= 1'b0;
               else         stage_q[g] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) stage_q[g] <= 1'b0;
               else         stage_q[g] <= stage_q[g-1];
            end
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/wdk_edge.sv
module wdk_edge (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic level_i,
   input  logic clear_i,
   output logic edge_o
);
   logic hist_q;
   logic hist_vld_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hist_q     <= 1'b0;
         hist_vld_q <= 1'b0;
      end else begin
         hist_q     <= level_i;
         hist_vld_q <= ~clear_i;
      end
   end

   assign edge_o = hist_vld_q & ~clear_i & (level_i ^ hist_q);
endmodule

// File: rtl/wdk_timer.sv
module wdk_timer
   import wdk_pkg::*;
#(
   parameter int TIMEOUT_TICKS = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clear_i,
   input  logic restart_i,
   output logic tripped_o
);
   localparam int CNT_W = (TIMEOUT_TICKS > 2) ? $clog2(TIMEOUT_TICKS) : 1;
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(TIMEOUT_TICKS - 1);

   wd_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= WD_IDLE;
         cnt_q   <= '0;
      end else if (clear_i) begin
         state_q <= WD_IDLE;
         cnt_q   <= '0;
      end else if (restart_i) begin
         state_q <= WD_RUN;
         cnt_q   <= LOAD_VAL;
      end else if (state_q == WD_RUN) begin
         if (cnt_q == '0) state_q <= WD_TRIP;
         else             cnt_q   <= cnt_q - 1'b1;
      end
   end

   assign tripped_o = (state_q == WD_TRIP);
endmodule

// File: rtl/wdk_monitor.sv
module wdk_monitor #(
   parameter int TIMEOUT_TICKS = 52429,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic kick_i,
   input  logic kick_hiz_i,
   input  logic supply_ok_i,
   input  logic rst_active_i,
   output logic wdo_no
);
   generate
      if (TIMEOUT_TICKS < 2) begin : g_bad_timeout
         $error("wdk_monitor: TIMEOUT_TICKS must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("wdk_monitor: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic kick_sync;
   logic hold_clear;
   logic kick_edge;
   logic tripped;

   assign hold_clear = kick_hiz_i | rst_active_i;

   wdk_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (kick_i),
      .q_o    (kick_sync)
   );

   wdk_edge i_edge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .level_i (kick_sync),
      .clear_i (hold_clear),
      .edge_o  (kick_edge)
   );

   wdk_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) i_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clear_i   (hold_clear),
      .restart_i (kick_edge),
      .tripped_o (tripped)
   );

   assign wdo_no = supply_ok_i & ~tripped;
endmodule

// File: rtl/wdk_monitor_chk.sv
module wdk_monitor_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic kick_hiz_i,
   input logic rst_active_i,
   input logic supply_ok_i,
   input logic wdo_no,
   input logic kick_edge,
   input logic tripped
);
   assert_supply_override_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !supply_ok_i |-> !wdo_no);

   assert_hiz_holds_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      kick_hiz_i |=> (!supply_ok_i || wdo_no));

   assert_reset_holds_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_active_i |=> (!supply_ok_i || wdo_no));

   assert_release_by_activity_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(tripped) |-> $past(kick_edge || kick_hiz_i || rst_active_i));

   assert_edge_beats_expiry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(tripped) |-> !$past(kick_edge));
endmodule

bind wdk_monitor wdk_monitor_chk i_wdk_monitor_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .kick_hiz_i   (kick_hiz_i),
   .rst_active_i (rst_active_i),
   .supply_ok_i  (supply_ok_i),
   .wdo_no       (wdo_no),
   .kick_edge    (kick_edge),
   .tripped      (tripped)
);

// File: tb/test_wdk_monitor.sv
module test_wdk_monitor;
   localparam int CLK_PERIOD = 10;
   localparam int T = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic kick = 1'b0;
   logic hiz = 1'b0;
   logic sup = 1'b1;
   logic ract = 1'b0;
   logic wdo_n;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   wdk_monitor #(.TIMEOUT_TICKS(T), .SYNC_STAGES(2)) i_wdk_monitor (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .kick_i       (kick),
      .kick_hiz_i   (hiz),
      .supply_ok_i  (sup),
      .rst_active_i (ract),
      .wdo_no       (wdo_n)
   );

   // Behavioural reference: sample queue, deadline timestamp, mode code
   bit     mq[$];
   bit     m_hist;
   bit     m_hv;
   int     m_mode;   // 0 idle, 1 counting, 2 expired
   longint m_dead;
   longint cyc;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mq = '{1'b0, 1'b0};
         m_hist = 1'b0; m_hv = 1'b0; m_mode = 0; m_dead = 0; cyc = 0;
      end else begin
         bit so, clr, ev;
         cyc++;
         so  = mq[0];
         clr = hiz | ract;
         ev  = m_hv && !clr && (so != m_hist);
         m_hist = so;
         m_hv   = !clr;
         if (clr) m_mode = 0;
         else if (ev) begin m_mode = 1; m_dead = cyc + T; end
         else if (m_mode == 1 && cyc >= m_dead) m_mode = 2;
         mq.push_back(kick);
         void'(mq.pop_front());
      end
   end

   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      if (rst_n && !done) begin
         logic expv;
         expv = sup && (m_mode != 2);
         checks++;
         if (wdo_n !== expv) begin
            errors++;
            $display("FAIL %s model compare: wdo_no actual %b expected %b at cycle %0d",
                     cur_req, wdo_n, expv, cyc);
         end
      end
   end

   task automatic check(input string req, input logic exp_v);
      checks++;
      if (wdo_n !== exp_v) begin
         errors++;
         $display("FAIL %s: wdo_no actual %b expected %b", req, wdo_n, exp_v);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #(CLK_PERIOD/4);
   endtask

   task automatic toggle_kick();
      @(negedge clk);
      kick = ~kick;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      finish_run();
   end

   initial begin
      // R1: reset state
      tick(3);
      @(negedge clk); rst_n = 1'b1;
      tick(1);
      check("R1", 1'b1);

      // R5: no timeout before any kick has been seen
      cur_req = "R5";
      tick(3*T);
      check("R5", 1'b1);

      // R3: exact expiry cycle, sticky low, release by next change
      cur_req = "R3";
      toggle_kick();
      tick(T+2);
      check("R3", 1'b1);
      tick(1);
      check("R3", 1'b0);
      tick(2*T);
      check("R3", 1'b0);
      toggle_kick();          // falling edge releases
      tick(2);
      check("R3", 1'b0);
      tick(1);
      check("R3", 1'b1);

      // R2: alternate polarity kicks keep it high, last one restarts full count
      cur_req = "R2";
      for (int i = 0; i < 10; i++) begin
         toggle_kick();
         tick(T/2 - 1);
         check("R2", 1'b1);
      end
      toggle_kick();
      tick(T+2);
      check("R2", 1'b1);
      tick(1);
      check("R2", 1'b0);

      // R8: kick load coincides with expiry edge
      cur_req = "R8";
      toggle_kick();
      tick(T);
      toggle_kick();
      tick(3);
      check("R8", 1'b1);
      tick(T-1);
      check("R8", 1'b1);
      tick(1);
      check("R8", 1'b0);

      // R7: single-cycle pulse is recognised
      cur_req = "R7";
      toggle_kick();
      toggle_kick();
      tick(3);
      check("R7", 1'b1);
      tick(T-1);
      check("R7", 1'b1);
      tick(1);
      check("R7", 1'b0);

      // R4: undriven kick line clears and holds
      cur_req = "R4";
      @(negedge clk); hiz = 1'b1;
      tick(1);
      check("R4", 1'b1);
      for (int i = 0; i < 5; i++) begin
         toggle_kick();
         tick(T/2);
      end
      tick(2*T);
      check("R4", 1'b1);
      tick(4);

      // R9: leaving undriven state with a changed level is not a kick
      cur_req = "R9";
      @(negedge clk); hiz = 1'b0;
      tick(3*T);
      check("R9", 1'b1);
      toggle_kick();
      tick(T+2);
      check("R9", 1'b1);
      tick(1);
      check("R9", 1'b0);

      // R5: reset active clears, counting only after a later kick
      cur_req = "R5";
      @(negedge clk); ract = 1'b1;
      tick(1);
      check("R5", 1'b1);
      toggle_kick();
      tick(3*T);
      check("R5", 1'b1);
      @(negedge clk); ract = 1'b0;
      tick(3*T);
      check("R5", 1'b1);
      toggle_kick();
      tick(T+2);
      check("R5", 1'b1);
      tick(1);
      check("R5", 1'b0);

      // R6: supply override, immediate in both directions
      cur_req = "R6";
      toggle_kick();
      tick(3);
      check("R6", 1'b1);
      @(negedge clk); sup = 1'b0;
      #1;
      check("R6", 1'b0);
      @(negedge clk); sup = 1'b1;
      #1;
      check("R6", 1'b1);
      tick(2);

      finish_run();
   end
endmodule